// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block sits between a processor port and a slower word-addressed main memory. It holds recently used memory blocks in 16 sets of two ways each, with 64 words per block, and answers reads that find their block resident without touching memory. The address tag is compared with both ways of the selected set at the same time.

Writes follow a write-through policy. Every accepted write goes into a four-entry FIFO, and the processor is released in the same cycle. The FIFO then writes each entry to memory in order, whenever the memory port is free. A write that finds its block resident also updates the cached word. A write that misses allocates nothing. A read miss first waits until no entry still in the FIFO belongs to the block it will fetch. It then reads the block from memory into an invalid way, or into the least recently used way of the set when both ways are valid.

Both ports use a request/acknowledge handshake. The processor holds `cpu_req` and its fields until `cpu_ack`. The cache holds `mem_req` and its fields until `mem_ack`, and each acknowledged memory cycle moves one word.

Top module: `wt_assoc_cache`

## Requirements
- R1: After reset, every way is invalid and both `cpu_ack` and `mem_req` are low. The first read of any address is therefore a miss.
- R2: A read whose block is resident is acknowledged in the cycle it is presented. `cpu_rdata` holds the cached word, and no memory cycle takes place.
- R3: On a read miss the cache reads all 64 words of the block from memory, one handshake per word, in ascending order starting at word 0. It acknowledges the read once the block is filled.
- R4: A 16-bit word address splits into tag bits [15:10], set bits [9:6] and word bits [5:0]. Two blocks whose block numbers differ by a multiple of 16 share a set and can be resident together. At most one way of a set ever matches a tag.
- R5: A fill goes to an invalid way of the set if there is one, way 0 before way 1. When both ways are valid, the fill goes to the least recently used way. Both hits and fills count as use.
- R6: Each accepted write produces exactly one memory write with the same address and data, and these writes leave in the order the processor issued them. `mem_req`, `mem_we` and `mem_addr` stay unchanged until `mem_ack`.
- R7: A write to a resident block updates the cached word. A later read returns the new value with no memory access.
- R8: A write to a block that is not resident does not allocate it. A later read of that block misses and fetches the block.
- R9: While fewer than 4 writes are waiting, a write is acknowledged in the cycle it is presented, whatever the memory is doing. With 4 waiting, `cpu_ack` stays low until one of them has been written to memory.
- R10: A read miss issues no memory read for its block while any waiting write to that block remains in the FIFO. The data returned reflects every write accepted before the read.
- R11: Under any mix of accesses, every read returns the most recent accepted write to that address, or the initial memory content if there was none. Once the FIFO is empty, memory holds the same image.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` on a read |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the transfer at this edge |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
If a tag, valid bit or LRU bit is wrong, the next read to that set shows it at once. Either the read's latency is wrong (a hit that costs 64 memory reads, or a miss acknowledged at once), or its data is wrong. If the write FIFO's order or occupancy is wrong, the memory write that leaves it has the wrong address or data. This shows within a few cycles, depending on how fast memory acknowledges. It can also show as a write acknowledged while four are waiting. A fill that starts before a matching FIFO entry drains shows up as stale read data as soon as the read completes. A final comparison of memory against the expected image catches writes that were lost or doubled.

// File: rtl/wtc_pkg.sv
// Shared definitions for the write-through associative cache.
// Assumes a fixed associativity of two (one LRU bit per set).
package wtc_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/wtc_tag_store.sv
// Tag, valid and LRU storage for a two-way cache.
// Compares a lookup tag with both ways of one set in parallel, reports the
// matching way and picks a victim (invalid way first, else the LRU way).
// Every update acts on the set being looked up, which the caller holds steady.
module wtc_tag_store #(
    parameter int TAG_W = 6,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [1:0]       hit_vec,
    output logic             victim,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             alloc_en,
    input  logic             alloc_way,
    input  logic             commit_en,
    input  logic             commit_way
);
    localparam int NSETS = 1 << SET_W;

    logic [NSETS-1:0] lru_q;
    logic [1:0]       vld_at_set;

    for (genvar w = 0; w < wtc_pkg::WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [NSETS];
        logic [NSETS-1:0] vld_q;

        // purpose: valid bits, cleared when a fill claims the way, set when it completes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else if (alloc_en && alloc_way == w[0]) begin
                vld_q[lk_set] <= 1'b0;
            end else if (commit_en && commit_way == w[0]) begin
                vld_q[lk_set] <= 1'b1;
            end
        end

        // purpose: tag written when a fill claims the way
        always_ff @(posedge clk) begin
            if (alloc_en && alloc_way == w[0]) begin
                tag_q[lk_set] <= lk_tag;
            end
        end

        assign vld_at_set[w] = vld_q[lk_set];
        assign hit_vec[w]    = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
    end

    // purpose: LRU bit names the way to evict next; the way just used becomes MRU
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[lk_set] <= ~touch_way;
        end
    end

    // purpose: victim choice, invalid way 0, then invalid way 1, then LRU
    always_comb begin
        if (!vld_at_set[0]) begin
            victim = 1'b0;
        end else if (!vld_at_set[1]) begin
            victim = 1'b1;
        end else begin
            victim = lru_q[lk_set];
        end
    end
endmodule

// File: rtl/wtc_data_store.sv
// Word storage for both ways. One write port (selected way) and one
// combinational read port that returns the addressed word of every way.
// Assumes at most one write per cycle; no reset on data.
module wtc_data_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic                              clk,
    input  logic                              wr_en,
    input  logic                              wr_way,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [IDX_W-1:0]                  rd_idx,
    output logic [wtc_pkg::WAYS-1:0][DATA_W-1:0] rd_data
);
    localparam int NWORDS = 1 << IDX_W;

    for (genvar w = 0; w < wtc_pkg::WAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem_q [NWORDS];

        // purpose: write the selected way's word
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == w[0]) begin
                mem_q[wr_idx] <= wr_data;
            end
        end

        assign rd_data[w] = mem_q[rd_idx];
    end
endmodule

// File: rtl/wtc_write_buffer.sv
// FIFO of posted writes (address + data). Presents the oldest entry at the
// head and reports whether any held entry falls in a probed memory block.
// Assumes push is never asserted when full and pop never when empty.
module wtc_write_buffer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int BLK_W  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [ADDR_W-1:0]            push_addr,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         pop,
    output logic [ADDR_W-1:0]            head_addr,
    output logic [DATA_W-1:0]            head_data,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    input  logic [BLK_W-1:0]             probe_blk,
    output logic                         probe_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  slot_match;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // purpose: pointers, occupancy count and per-slot valid bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            vld_q    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q         <= ptr_next(wr_ptr_q);
                vld_q[wr_ptr_q]  <= 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q         <= ptr_next(rd_ptr_q);
                vld_q[rd_ptr_q]  <= 1'b0;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // purpose: capture the pushed entry
    always_ff @(posedge clk) begin
        if (do_push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_probe
        assign slot_match[i] = vld_q[i] && (addr_q[i][ADDR_W-1 -: BLK_W] == probe_blk);
    end

    assign probe_hit = |slot_match;
    assign head_addr = addr_q[rd_ptr_q];
    assign head_data = data_q[rd_ptr_q];
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign level     = cnt_q;
endmodule

// File: rtl/wt_assoc_cache.sv
// Two-way set-associative write-through cache with a posted-write FIFO.
// Read hits and accepted writes complete combinationally in the request
// cycle. A read miss waits for buffered writes to its block to drain, then
// fills the whole block from memory word by word and completes on a re-lookup.
// Assumes the processor holds its request fields steady until cpu_ack.
module wt_assoc_cache #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int SET_W    = 4,
    parameter int OFF_W    = 6,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    import wtc_pkg::*;

    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int IDX_W = SET_W + OFF_W;
    localparam int CNT_W = $clog2(WB_DEPTH + 1);

    // address fields
    logic [TAG_W-1:0] cpu_tag;
    logic [SET_W-1:0] cpu_set;
    logic [OFF_W-1:0] cpu_off;
    logic [BLK_W-1:0] cpu_blk;

    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_set = cpu_addr[OFF_W +: SET_W];
    assign cpu_off = cpu_addr[OFF_W-1:0];
    assign cpu_blk = cpu_addr[ADDR_W-1:OFF_W];

    // control state
    ctl_state_t       state_q;
    logic             fill_way_q;
    logic [OFF_W-1:0] fill_cnt_q;

    // lookup results and buffer status
    logic [1:0]       hit_vec;
    logic             hit, hit_way, victim;
    logic             wb_full, wb_empty, blk_pending;
    logic [CNT_W-1:0] wb_level;
    logic [ADDR_W-1:0] wb_head_addr;
    logic [DATA_W-1:0] wb_head_data;
    logic [WAYS-1:0][DATA_W-1:0] way_rdata;

    // decoded events
    logic in_idle, filling, rd_hit_ack, wr_ack, rd_miss;
    logic fill_beat, fill_last, drain_done, wb_pop;

    assign hit        = |hit_vec;
    assign hit_way    = hit_vec[1];
    assign in_idle    = (state_q == ST_IDLE);
    assign filling    = (state_q == ST_FILL);
    assign rd_hit_ack = in_idle && cpu_req && !cpu_we && hit;
    assign wr_ack     = in_idle && cpu_req && cpu_we && !wb_full;
    assign rd_miss    = in_idle && cpu_req && !cpu_we && !hit;
    assign fill_beat  = filling && mem_ack;
    assign fill_last  = fill_beat && (fill_cnt_q == {OFF_W{1'b1}});
    assign drain_done = (state_q == ST_DRAIN) && !blk_pending && (wb_empty || mem_ack);
    assign wb_pop     = !filling && !wb_empty && mem_ack;

    assign cpu_ack   = rd_hit_ack || wr_ack;
    assign cpu_rdata = way_rdata[hit_way];

    // memory port: fill owns it while filling, else the FIFO head drains
    assign mem_req   = filling || !wb_empty;
    assign mem_we    = !filling;
    assign mem_addr  = filling ? {cpu_blk, fill_cnt_q} : wb_head_addr;
    assign mem_wdata = wb_head_data;

    wtc_tag_store #(
        .TAG_W (TAG_W),
        .SET_W (SET_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_set     (cpu_set),
        .lk_tag     (cpu_tag),
        .hit_vec    (hit_vec),
        .victim     (victim),
        .touch_en   (rd_hit_ack || (wr_ack && hit) || fill_last),
        .touch_way  (filling ? fill_way_q : hit_way),
        .alloc_en   (rd_miss),
        .alloc_way  (victim),
        .commit_en  (fill_last),
        .commit_way (fill_way_q)
    );

    wtc_data_store #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (fill_beat || (wr_ack && hit)),
        .wr_way  (filling ? fill_way_q : hit_way),
        .wr_idx  ({cpu_set, (filling ? fill_cnt_q : cpu_off)}),
        .wr_data (filling ? mem_rdata : cpu_wdata),
        .rd_idx  ({cpu_set, cpu_off}),
        .rd_data (way_rdata)
    );

    wtc_write_buffer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (WB_DEPTH),
        .BLK_W  (BLK_W)
    ) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_ack),
        .push_addr (cpu_addr),
        .push_data (cpu_wdata),
        .pop       (wb_pop),
        .head_addr (wb_head_addr),
        .head_data (wb_head_data),
        .full      (wb_full),
        .empty     (wb_empty),
        .level     (wb_level),
        .probe_blk (cpu_blk),
        .probe_hit (blk_pending)
    );

    // purpose: miss sequencing, idle -> wait for block writes -> fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fill_way_q <= 1'b0;
            fill_cnt_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (rd_miss) begin
                        state_q    <= ST_DRAIN;
                        fill_way_q <= victim;
                        fill_cnt_q <= '0;
                    end
                end
                ST_DRAIN: begin
                    if (drain_done) begin
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (fill_last) begin
                        state_q <= ST_IDLE;
                    end
                    if (fill_beat) begin
                        fill_cnt_q <= fill_cnt_q + {{(OFF_W-1){1'b0}}, 1'b1};
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wt_assoc_cache_chk.sv
// Property checker for wt_assoc_cache, attached by bind below.
// Observes ports plus internal lookup, buffer and fill signals.
module wt_assoc_cache_chk #(
    parameter int ADDR_W   = 16,
    parameter int OFF_W    = 6,
    parameter int WB_DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cpu_req,
    input logic                       cpu_we,
    input logic                       cpu_ack,
    input logic                       mem_req,
    input logic                       mem_we,
    input logic                       mem_ack,
    input logic [ADDR_W-1:0]          mem_addr,
    input logic [1:0]                 hit_vec,
    input logic [$clog2(WB_DEPTH+1)-1:0] wb_level,
    input logic                       blk_pending,
    input logic                       filling,
    input logic [OFF_W-1:0]           fill_cnt
);
    assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_req);

    assert_fill_step_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (filling && !mem_ack) |=> $stable(fill_cnt));

    assert_one_way_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_level <= ($clog2(WB_DEPTH+1))'(WB_DEPTH));

    assert_full_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && wb_level == ($clog2(WB_DEPTH+1))'(WB_DEPTH)) |-> !cpu_ack);

    assert_fill_after_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filling) |-> !blk_pending);
endmodule

bind wt_assoc_cache wt_assoc_cache_chk #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .WB_DEPTH (WB_DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_ack     (cpu_ack),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .hit_vec     (hit_vec),
    .wb_level    (wb_level),
    .blk_pending (blk_pending),
    .filling     (filling),
    .fill_cnt    (fill_cnt_q)
);

// File: tb/wt_assoc_cache_tb.sv
module wt_assoc_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    wt_assoc_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_checks = 0, n_fail = 0;
    bit hold_mem = 1'b0, done = 1'b0;
    int rd_total = 0, wr_total = 0, n_writes = 0;
    int seq_err = 0, order_err = 0, wr_err = 0;
    int rd_next_off = 0;
    logic [9:0]  rd_blk_cur = '0;
    logic [15:0] pend_addr [$];
    logic [31:0] pend_data [$];
    logic [31:0] mem_model [int];
    logic [31:0] ref_mem [int];

    function automatic logic [31:0] init_val(input logic [15:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    function automatic logic [15:0] mk(input int tag, input int set, input int off);
        return {tag[5:0], set[3:0], off[5:0]};
    endfunction

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
    endfunction

    function automatic logic [31:0] mem_read(input logic [15:0] a);
        return mem_model.exists(int'(a)) ? mem_model[int'(a)] : init_val(a);
    endfunction

    // Memory model: decides the acknowledge at the falling edge; transfer commits at the next rising edge.
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (rst_n && mem_req && !hold_mem && ($urandom_range(3) != 0)) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                wr_total++;
                mem_model[int'(mem_addr)] = mem_wdata;
                if (pend_addr.size() == 0 || pend_addr[0] != mem_addr || pend_data[0] != mem_wdata) begin
                    wr_err++;
                end else begin
                    void'(pend_addr.pop_front());
                    void'(pend_data.pop_front());
                end
            end else begin
                rd_total++;
                mem_rdata = mem_read(mem_addr);
                if (mem_addr[5:0] == 6'd0) begin
                    rd_blk_cur = mem_addr[15:6];
                    foreach (pend_addr[i]) if (pend_addr[i][15:6] == mem_addr[15:6]) order_err++;
                end else if (mem_addr[15:6] != rd_blk_cur || int'(mem_addr[5:0]) != rd_next_off) begin
                    seq_err++;
                end
                rd_next_off = int'(mem_addr[5:0]) + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [15:0] a, input logic [31:0] d,
                          output logic [31:0] q, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; lat = 0;
        #1;
        while (!cpu_ack) begin
            @(negedge clk); #1; lat++;
        end
        q = cpu_rdata;
        if (we) begin
            ref_mem[int'(a)] = d;
            pend_addr.push_back(a);
            pend_data.push_back(d);
            n_writes++;
        end
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input string req, output int lat);
        logic [31:0] q;
        access(1'b0, a, '0, q, lat);
        check(q == exp_read(a), req, "read data", q, exp_read(a));
    endtask

    task automatic wait_drain();
        do @(negedge clk); while (mem_req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, r0, lat5, bad;
        bit stalled;
        logic [31:0] q;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ack == 1'b0, "R1", "cpu_ack after reset", 32'(cpu_ack), 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);

        // R1 / R3: first read misses and fetches a whole block in order
        r0 = rd_total;
        do_read(mk(1, 3, 5), "R3", lat);
        check(lat > 0, "R1", "first read latency", lat, 1);
        check(rd_total - r0 == 64, "R3", "words fetched on miss", rd_total - r0, 64);
        check(seq_err == 0, "R3", "fill word order errors", seq_err, 0);

        // R2: hit answers in the request cycle with no memory traffic
        r0 = rd_total;
        do_read(mk(1, 3, 40), "R2", lat);
        check(lat == 0, "R2", "hit latency", lat, 0);
        check(rd_total == r0, "R2", "memory reads on hit", rd_total - r0, 0);

        // R4: second block of the same set coexists
        do_read(mk(2, 3, 1), "R4", lat);
        r0 = rd_total;
        do_read(mk(1, 3, 2), "R4", lat);
        check(lat == 0 && rd_total == r0, "R4", "first block still resident", lat, 0);

        // R5: third block evicts the least recently used one
        do_read(mk(3, 3, 0), "R5", lat);
        do_read(mk(1, 3, 9), "R5", lat);
        check(lat == 0, "R5", "recently used block kept", lat, 0);
        r0 = rd_total;
        do_read(mk(2, 3, 9), "R5", lat);
        check(rd_total - r0 == 64, "R5", "LRU block was evicted", rd_total - r0, 64);

        // R7: write hit updates cached word
        access(1'b1, mk(1, 3, 7), 32'hCAFE_0007, q, lat);
        check(lat == 0, "R9", "write ack latency", lat, 0);
        r0 = rd_total;
        do_read(mk(1, 3, 7), "R7", lat);
        check(lat == 0 && rd_total == r0, "R7", "read after write hit is a hit", rd_total - r0, 0);

        // R8: write miss does not allocate
        access(1'b1, mk(4, 5, 3), 32'h0BAD_F00D, q, lat);
        r0 = rd_total;
        do_read(mk(4, 5, 3), "R10", lat);
        check(rd_total - r0 == 64, "R8", "read after write miss fetches", rd_total - r0, 64);

        // R9: four writes post at once with memory stalled, the fifth waits
        wait_drain();
        hold_mem = 1'b1;
        for (int i = 0; i < 4; i++) begin
            access(1'b1, mk(6, 7, i), 32'h6000_0000 + i, q, lat);
            check(lat == 0, "R9", "posted write latency", lat, 0);
        end
        stalled = 1'b1;
        fork
            access(1'b1, mk(6, 7, 4), 32'h6000_0004, q, lat5);
            begin
                repeat (6) begin @(negedge clk); #2; if (cpu_ack) stalled = 1'b0; end
                hold_mem = 1'b0;
            end
        join
        check(stalled, "R9", "write held while buffer full", 32'(stalled), 1);
        check(lat5 > 5, "R9", "fifth write latency", lat5, 6);

        // R10: read miss behind a buffered write to the same block
        wait_drain();
        hold_mem = 1'b1;
        access(1'b1, mk(8, 9, 9), 32'h8888_0909, q, lat);
        hold_mem = 1'b0;
        do_read(mk(8, 9, 9), "R10", lat);

        // R11: random mix over a few conflicting blocks
        for (int n = 0; n < 700; n++) begin
            logic [15:0] a;
            a = mk(10 + $urandom_range(3), $urandom_range(2), $urandom_range(63));
            if ($urandom_range(2) == 0) access(1'b1, a, $urandom, q, lat);
            else do_read(a, "R11", lat);
        end

        wait_drain();
        bad = 0;
        foreach (ref_mem[k]) if (mem_read(16'(k)) != ref_mem[k]) bad++;
        check(bad == 0, "R11", "memory image mismatches", bad, 0);
        check(wr_err == 0, "R6", "memory write mismatches", wr_err, 0);
        check(wr_total == n_writes, "R6", "memory write count", wr_total, n_writes);
        check(pend_addr.size() == 0, "R6", "writes never issued", pend_addr.size(), 0);
        check(order_err == 0, "R10", "fill before buffered write", order_err, 0);
        check(seq_err == 0, "R3", "fill order errors overall", seq_err, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule